// File: doc/BRIEF.md
# Switch Reset and Port-State Sequencer

This block runs on the host side of a managed multiport switch. It brings the switch into a known state through a single register-access channel. When `start_i` is pulsed, it walks the ports from the lowest number to the highest and puts each one in the blocked state. It then lets the switch queues empty for a fixed time and raises the self-clearing soft-reset bit in the switch's global control register. Finally it polls that bit at a fixed interval until the bit clears or the try budget runs out.

Between reset runs the same engine serves single-port commands. Each command moves one port to forwarding or to blocked and leaves every other bit of that port's control register as it was.

All register traffic uses one request/response channel. A request is held until the far side answers with read data or an error. The outcome of every operation is shown by a one-cycle completion pulse plus sticky error and timeout flags.

Top module: `swrst_port_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `req_valid_o`, `done_o`, `err_o` and `tmo_o` are all low.
- R2: Every port-state change is a read of the control register (offset 0x04) at device `PORT_BASE + port`, followed by a write to the same place. The written value equals the read value with only bits 1:0 replaced. Every request uses register offset 0x04.
- R3: A reset run first blocks every port, writing state value 0 in bits 1:0. It does this in ascending order from port 0 to `NUM_PORTS-1`.
- R4: After the response to the last port write, the block issues no request for `DRAIN_MS*CYC_PER_MS` cycles. It then reads the global control register (device `GLOBAL_DEV`, offset 0x04), no more than 2 cycles after that window ends.
- R5: The global control register is written back with bit 15 set and all other bits equal to the value just read.
- R6: Right after the global write completes, the block reads global control. After each read that shows bit 15 set, it waits `CYC_PER_MS` cycles, with up to 2 cycles of slack, and reads again. The first read with bit 15 clear ends the run with `done_o` pulsed and `err_o` low.
- R7: If `POLL_TRIES` polling reads all show bit 15 set, the run ends with `done_o` pulsed and both `err_o` and `tmo_o` high, and no further request is made.
- R8: A port command with `pcmd_enable_i`=1 writes state value 3 (forwarding). With `pcmd_enable_i`=0 it writes value 0 (blocked). The command ends with a one-cycle `done_o` pulse and `err_o` low.
- R9: An error response to any request ends the operation at once. `done_o` pulses, `err_o` goes high, `tmo_o` stays low, and no further request follows. `err_o` and `tmo_o` hold until the next accepted start or command clears them.
- R10: A port command naming a port at or above `NUM_PORTS` makes no request and ends with `done_o` pulsed and `err_o` high.
- R11: `start_i` and port commands are taken only while idle; while busy they are ignored. When both arrive in the same idle cycle, the reset run wins.
- R12: A request stays asserted, with device, direction and write data unchanged, until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a full reset run (taken while idle) |
| pcmd_valid_i | input | 1 | Single-port state command (taken while idle) |
| pcmd_port_i | input | PORT_W | Port number for the command |
| pcmd_enable_i | input | 1 | 1: forwarding, 0: blocked |
| req_valid_o | output | 1 | Register request pending |
| req_write_o | output | 1 | 1: write, 0: read |
| req_dev_o | output | 5 | Device address of the request |
| req_reg_o | output | 5 | Register offset of the request |
| req_wdata_o | output | 16 | Write data |
| rsp_valid_i | input | 1 | Response for the pending request |
| rsp_err_i | input | 1 | Response carries an error |
| rsp_rdata_i | input | 16 | Read data of the response |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when an operation ends |
| err_o | output | 1 | Last operation failed (sticky) |
| tmo_o | output | 1 | Last run timed out polling the reset bit (sticky) |

## Verification
The bench goes after four things:
- Read data whose upper bits are irregular. A merge that clears or rebuilds the whole register, instead of only the two-bit field, shows up as a wrong write value.
- The gaps before the global read and between polls, measured in cycles. An off-by-one or missing millisecond wait shows up as a gap outside the allowed window.
- Exhaustion of the full poll budget. Stopping one read early or late leaves the expected request queue unbalanced or adds an unexpected request.
- An error response in the middle of a run, a command to an out-of-range port, a start and a command in the same cycle, and a command raised while busy. A design that keeps going, touches the bus, or picks the wrong request produces requests the scoreboard rejects.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
    localparam int DATA_W  = 16;
    localparam int DEV_W   = 5;
    localparam int REG_W   = 5;
    localparam int FIELD_W = 2;     // port-state field, bits 1:0
    localparam int RST_BIT = 15;    // self-clearing soft-reset bit

    localparam logic [REG_W-1:0]   CTRL_REG = 5'h04;
    localparam logic [FIELD_W-1:0] PST_OFF  = 2'd0;
    localparam logic [FIELD_W-1:0] PST_FWD  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PORT_RD,
        ST_PORT_WR,
        ST_DRAIN,
        ST_GLB_RD,
        ST_GLB_WR,
        ST_POLL,
        ST_GAP
    } seq_st_e;
endpackage

// File: rtl/swrst_ms_timer.sv
module swrst_ms_timer #(
    parameter int CYC_PER_MS = 125000,
    parameter int MAX_MS     = 2,
    parameter int MS_W       = $clog2(MAX_MS + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic [MS_W-1:0] ms_i,
    output logic            fin_o
);
    localparam int CW = $clog2(CYC_PER_MS + 1);

    typedef struct packed {
        logic            run;
        logic [CW-1:0]   cyc;
        logic [MS_W-1:0] ms;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    // Fires in the last cycle of the loaded window.
    assign fin_o = tmr_q.run && (tmr_q.cyc == '0) && (tmr_q.ms == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cyc = CW'(CYC_PER_MS - 1);
            tmr_d.ms  = ms_i - MS_W'(1);
        end else if (tmr_q.run) begin
            if (tmr_q.cyc != '0) begin
                tmr_d.cyc = tmr_q.cyc - CW'(1);
            end else if (tmr_q.ms != '0) begin
                tmr_d.ms  = tmr_q.ms - MS_W'(1);
                tmr_d.cyc = CW'(CYC_PER_MS - 1);
            end else begin
                tmr_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end
endmodule

// File: rtl/swrst_rmw_merge.sv
module swrst_rmw_merge import swrst_pkg::*; (
    input  logic [DATA_W-1:0]  rdata_i,
    input  logic               set_rst_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [DATA_W-1:0]  wdata_o
);
    // Port mode replaces the low field; global mode sets the reset bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < FIELD_W) begin : g_field
            assign wdata_o[b] = set_rst_i ? rdata_i[b] : field_i[b];
        end else if (b == RST_BIT) begin : g_rst
            assign wdata_o[b] = set_rst_i | rdata_i[b];
        end else begin : g_keep
            assign wdata_o[b] = rdata_i[b];
        end
    end
endmodule

// File: rtl/swrst_port_seq.sv
module swrst_port_seq import swrst_pkg::*; #(
    parameter int               NUM_PORTS  = 7,
    parameter int               PORT_W     = $clog2(NUM_PORTS),
    parameter logic [DEV_W-1:0] PORT_BASE  = 5'h10,
    parameter logic [DEV_W-1:0] GLOBAL_DEV = 5'h1B,
    parameter int               CYC_PER_MS = 125000,
    parameter int               DRAIN_MS   = 2,
    parameter int               POLL_TRIES = 1000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              pcmd_valid_i,
    input  logic [PORT_W-1:0] pcmd_port_i,
    input  logic              pcmd_enable_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [DEV_W-1:0]  req_dev_o,
    output logic [REG_W-1:0]  req_reg_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_err_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              tmo_o
);
    localparam int TRY_W  = $clog2(POLL_TRIES + 1);
    localparam int MAX_MS = (DRAIN_MS > 1) ? DRAIN_MS : 1;
    localparam int MS_W   = $clog2(MAX_MS + 1);

    typedef struct packed {
        seq_st_e             st;
        logic [PORT_W-1:0]   idx;
        logic                rst_mode;
        logic [FIELD_W-1:0]  fval;
        logic [DATA_W-1:0]   rd;
        logic [TRY_W-1:0]    tries;
        logic                done;
        logic                err;
        logic                tmo;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              tmr_load;
    logic [MS_W-1:0]   tmr_ms;
    logic              tmr_fin;
    logic              in_req;
    logic              got_rsp;
    logic [DATA_W-1:0] merged;

    swrst_ms_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .MAX_MS     (MAX_MS),
        .MS_W       (MS_W)
    ) i_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .ms_i   (tmr_ms),
        .fin_o  (tmr_fin)
    );

    swrst_rmw_merge i_merge (
        .rdata_i   (seq_q.rd),
        .set_rst_i (seq_q.st == ST_GLB_WR),
        .field_i   (seq_q.fval),
        .wdata_o   (merged)
    );

    assign in_req = (seq_q.st == ST_PORT_RD) || (seq_q.st == ST_PORT_WR) ||
                    (seq_q.st == ST_GLB_RD)  || (seq_q.st == ST_GLB_WR)  ||
                    (seq_q.st == ST_POLL);
    assign got_rsp = in_req && rsp_valid_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_ms     = MS_W'(1);

        if (got_rsp && rsp_err_i) begin
            // any failed access ends the operation
            seq_d.st   = ST_IDLE;
            seq_d.err  = 1'b1;
            seq_d.done = 1'b1;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        seq_d.st       = ST_PORT_RD;
                        seq_d.idx      = '0;
                        seq_d.rst_mode = 1'b1;
                        seq_d.fval     = PST_OFF;
                        seq_d.err      = 1'b0;
                        seq_d.tmo      = 1'b0;
                    end else if (pcmd_valid_i) begin
                        seq_d.err = 1'b0;
                        seq_d.tmo = 1'b0;
                        if (int'(pcmd_port_i) < NUM_PORTS) begin
                            seq_d.st       = ST_PORT_RD;
                            seq_d.idx      = pcmd_port_i;
                            seq_d.rst_mode = 1'b0;
                            seq_d.fval     = pcmd_enable_i ? PST_FWD : PST_OFF;
                        end else begin
                            seq_d.err  = 1'b1;
                            seq_d.done = 1'b1;
                        end
                    end
                end
                ST_PORT_RD: begin
                    if (got_rsp) begin
                        seq_d.rd = rsp_rdata_i;
                        seq_d.st = ST_PORT_WR;
                    end
                end
                ST_PORT_WR: begin
                    if (got_rsp) begin
                        if (!seq_q.rst_mode) begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                        end else if (seq_q.idx == PORT_W'(NUM_PORTS - 1)) begin
                            seq_d.st = ST_DRAIN;
                            tmr_load = 1'b1;
                            tmr_ms   = MS_W'(DRAIN_MS);
                        end else begin
                            seq_d.idx = seq_q.idx + PORT_W'(1);
                            seq_d.st  = ST_PORT_RD;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (tmr_fin) seq_d.st = ST_GLB_RD;
                end
                ST_GLB_RD: begin
                    if (got_rsp) begin
                        seq_d.rd = rsp_rdata_i;
                        seq_d.st = ST_GLB_WR;
                    end
                end
                ST_GLB_WR: begin
                    if (got_rsp) begin
                        seq_d.tries = '0;
                        seq_d.st    = ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (got_rsp) begin
                        if (!rsp_rdata_i[RST_BIT]) begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                        end else if (seq_q.tries == TRY_W'(POLL_TRIES - 1)) begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                            seq_d.err  = 1'b1;
                            seq_d.tmo  = 1'b1;
                        end else begin
                            seq_d.tries = seq_q.tries + TRY_W'(1);
                            seq_d.st    = ST_GAP;
                            tmr_load    = 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tmr_fin) seq_d.st = ST_POLL;
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{st: ST_IDLE, default: '0};
        else         seq_q <= seq_d;
    end

    assign req_valid_o = in_req;
    assign req_write_o = (seq_q.st == ST_PORT_WR) || (seq_q.st == ST_GLB_WR);
    assign req_dev_o   = ((seq_q.st == ST_PORT_RD) || (seq_q.st == ST_PORT_WR))
                         ? PORT_BASE + DEV_W'(seq_q.idx) : GLOBAL_DEV;
    assign req_reg_o   = CTRL_REG;
    assign req_wdata_o = merged;
    assign busy_o      = (seq_q.st != ST_IDLE);
    assign done_o      = seq_q.done;
    assign err_o       = seq_q.err;
    assign tmo_o       = seq_q.tmo;
endmodule

// File: rtl/swrst_port_seq_chk.sv
module swrst_port_seq_chk import swrst_pkg::*; #(
    parameter logic [DEV_W-1:0] GLOBAL_DEV = 5'h1B
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_o,
    input logic              req_write_o,
    input logic [DEV_W-1:0]  req_dev_o,
    input logic [REG_W-1:0]  req_reg_o,
    input logic [DATA_W-1:0] req_wdata_o,
    input logic              rsp_valid_i,
    input logic              rsp_err_i,
    input logic [DATA_W-1:0] rsp_rdata_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              tmo_o
);
    // Last data returned to a read, observed at the channel.
    logic [DATA_W-1:0] last_rd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                      last_rd_q <= '0;
        else if (req_valid_o && !req_write_o && rsp_valid_i) last_rd_q <= rsp_rdata_i;
    end

    // R2: every access targets the control register offset
    a_r2_ctrl_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> (req_reg_o == CTRL_REG));

    // R2: port write keeps every bit above the state field
    a_r2_field_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && req_write_o && req_dev_o != GLOBAL_DEV)
        |-> (req_wdata_o[DATA_W-1:FIELD_W] == last_rd_q[DATA_W-1:FIELD_W]));

    // R5: global write is the read value with the reset bit set
    a_r5_set_rst_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && req_write_o && req_dev_o == GLOBAL_DEV)
        |-> (req_wdata_o == (last_rd_q | 16'h8000)));

    // R12: request held steady until answered
    a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && !rsp_valid_i)
        |=> (req_valid_o && $stable(req_dev_o) && $stable(req_write_o) && $stable(req_wdata_o)));

    // R9: error response ends the operation with the error flag
    a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && rsp_valid_i && rsp_err_i) |=> (!busy_o && done_o && err_o && !tmo_o));

    // R9: nothing is requested while idle
    a_r9_no_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !req_valid_o);

    // R7: a timeout is always reported as an error too
    a_r7_tmo_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_o |-> err_o);

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
endmodule

bind swrst_port_seq swrst_port_seq_chk #(.GLOBAL_DEV(GLOBAL_DEV)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_o (req_valid_o),
    .req_write_o (req_write_o),
    .req_dev_o   (req_dev_o),
    .req_reg_o   (req_reg_o),
    .req_wdata_o (req_wdata_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_err_i   (rsp_err_i),
    .rsp_rdata_i (rsp_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .tmo_o       (tmo_o)
);

// File: tb/test_swrst_port_seq.sv
`timescale 1ns/1ps
module test_swrst_port_seq;
    localparam int         NP    = 7;
    localparam int         PW    = $clog2(NP);
    localparam logic [4:0] PB    = 5'h10;
    localparam logic [4:0] GD    = 5'h1B;
    localparam int         CPM   = 8;
    localparam int         DRAIN = 2;
    localparam int         TRIES = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          pcmd_valid_i = 1'b0;
    logic [PW-1:0] pcmd_port_i = '0;
    logic          pcmd_enable_i = 1'b0;
    logic          req_valid_o, req_write_o;
    logic [4:0]    req_dev_o, req_reg_o;
    logic [15:0]   req_wdata_o;
    logic          rsp_valid_i = 1'b0;
    logic          rsp_err_i = 1'b0;
    logic [15:0]   rsp_rdata_i = '0;
    logic          busy_o, done_o, err_o, tmo_o;

    always #4 clk = ~clk;   // 125 MHz

    swrst_port_seq #(
        .NUM_PORTS (NP), .PORT_BASE (PB), .GLOBAL_DEV (GD),
        .CYC_PER_MS (CPM), .DRAIN_MS (DRAIN), .POLL_TRIES (TRIES)
    ) i_swrst_port_seq (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start_i),
        .pcmd_valid_i (pcmd_valid_i), .pcmd_port_i (pcmd_port_i),
        .pcmd_enable_i (pcmd_enable_i),
        .req_valid_o (req_valid_o), .req_write_o (req_write_o),
        .req_dev_o (req_dev_o), .req_reg_o (req_reg_o), .req_wdata_o (req_wdata_o),
        .rsp_valid_i (rsp_valid_i), .rsp_err_i (rsp_err_i), .rsp_rdata_i (rsp_rdata_i),
        .busy_o (busy_o), .done_o (done_o), .err_o (err_o), .tmo_o (tmo_o)
    );

    typedef struct {
        bit          wr;
        logic [4:0]  dev;
        logic [15:0] wd;
        logic [15:0] rd;
        bit          er;
        int          gap;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   nvec = 0;
    int   nbad = 0;
    int   cyc = 0;
    int   last_rsp_cyc = 0;
    int   nrsp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_rd(input logic [4:0] dev, input logic [15:0] rd,
                           input bit er, input int gap, input string tag);
        exp_t e;
        e.wr = 1'b0; e.dev = dev; e.wd = '0; e.rd = rd; e.er = er; e.gap = gap; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic push_wr(input logic [4:0] dev, input logic [15:0] wd,
                           input bit er, input string tag);
        exp_t e;
        e.wr = 1'b1; e.dev = dev; e.wd = wd; e.rd = '0; e.er = er; e.gap = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    // Expected traffic of a full reset run (R3, R4, R5, R6, R7)
    task automatic push_reset(input logic [15:0] seed, input logic [15:0] grd,
                              input int nbusy, input bit clears);
        for (int p = 0; p < NP; p++) begin
            logic [15:0] v;
            v = seed + 16'(p * 37);
            push_rd(PB + 5'(p), v, 1'b0, 0, "R3");
            push_wr(PB + 5'(p), v & 16'hFFFC, 1'b0, "R3");
        end
        push_rd(GD, grd, 1'b0, DRAIN * CPM, "R4");
        push_wr(GD, grd | 16'h8000, 1'b0, "R5");
        for (int i = 0; i < nbusy; i++)
            push_rd(GD, 16'h8000 | 16'(i), 1'b0, (i == 0) ? 0 : CPM, nbusy == TRIES ? "R7" : "R6");
        if (clears)
            push_rd(GD, 16'h0041, 1'b0, (nbusy == 0) ? 0 : CPM, "R6");
    endtask

    // Responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (req_valid_o) begin
                exp_t e;
                int   g;
                g = cyc - last_rsp_cyc;
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected request dev", req_dev_o, 0);
                    e.wr = 1'b0; e.dev = req_dev_o; e.wd = '0; e.rd = '0; e.er = 1'b1;
                    e.gap = 0; e.tag = "R9";
                end else begin
                    e = sb.pop_front();
                    chk(req_write_o == e.wr, e.tag, "direction", req_write_o, e.wr);
                    chk(req_dev_o == e.dev, e.tag, "device", req_dev_o, e.dev);
                    chk(req_reg_o == 5'h04, "R2", "register offset", req_reg_o, 5'h04);
                    if (e.wr) chk(req_wdata_o == e.wd, e.tag, "write data", req_wdata_o, e.wd);
                    if (e.gap > 0)
                        chk(g >= e.gap && g <= e.gap + 2, e.tag, "gap cycles", g, e.gap);
                end
                repeat (nrsp % 3) @(negedge clk);
                nrsp++;
                rsp_valid_i  = 1'b1;
                rsp_err_i    = e.er;
                rsp_rdata_i  = e.rd;
                last_rsp_cyc = cyc;
                @(negedge clk);
                rsp_valid_i = 1'b0;
                rsp_err_i   = 1'b0;
            end
        end
    end

    task automatic wait_done(input string tag, input bit exp_err, input bit exp_tmo);
        int n;
        n = 0;
        while (!done_o && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o, tag, "done pulse", done_o, 1);
        chk(err_o == exp_err, tag, "err flag", err_o, exp_err);
        chk(tmo_o == exp_tmo, tag, "timeout flag", tmo_o, exp_tmo);
        @(negedge clk);
        chk(!done_o, tag, "done lasts one cycle", done_o, 0);
        chk(!busy_o, tag, "idle after done", busy_o, 0);
        chk(sb.size() == 0, tag, "expected requests left", sb.size(), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic port_cmd(input int port, input bit en);
        @(negedge clk);
        pcmd_valid_i  = 1'b1;
        pcmd_port_i   = PW'(port);
        pcmd_enable_i = en;
        @(negedge clk);
        pcmd_valid_i = 1'b0;
    endtask

    task automatic start_run();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        chk(!busy_o && !req_valid_o, "R1", "busy/req after reset", {busy_o, req_valid_o}, 0);
        chk(!done_o && !err_o && !tmo_o, "R1", "flags after reset", {done_o, err_o, tmo_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !req_valid_o, "R1", "idle after release", {busy_o, req_valid_o}, 0);

        // R8/R2: enable port 2, upper bits kept
        push_rd(PB + 5'd2, 16'hA5A4, 1'b0, 0, "R2");
        push_wr(PB + 5'd2, 16'hA5A7, 1'b0, "R8");
        port_cmd(2, 1'b1);
        wait_done("R8", 1'b0, 1'b0);

        // R8: disable port 6 from all ones
        push_rd(PB + 5'd6, 16'hFFFF, 1'b0, 0, "R2");
        push_wr(PB + 5'd6, 16'hFFFC, 1'b0, "R8");
        port_cmd(6, 1'b0);
        wait_done("R8", 1'b0, 1'b0);

        // R10: out-of-range port makes no access
        port_cmd(7, 1'b1);
        wait_done("R10", 1'b1, 1'b0);

        // R11: start and command together -> reset run; later command while busy ignored
        push_reset(16'h1233, 16'h4001, 3, 1'b1);
        @(negedge clk);
        start_i = 1'b1; pcmd_valid_i = 1'b1; pcmd_port_i = PW'(4); pcmd_enable_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; pcmd_valid_i = 1'b0;
        repeat (5) @(negedge clk);
        pcmd_valid_i = 1'b1; pcmd_port_i = PW'(1);
        @(negedge clk);
        pcmd_valid_i = 1'b0;
        wait_done("R11", 1'b0, 1'b0);

        // R6: bit already clear at the first poll
        push_reset(16'h0F0E, 16'h0000, 0, 1'b1);
        start_run();
        wait_done("R6", 1'b0, 1'b0);

        // R7: reset bit never clears
        push_reset(16'h7777, 16'h0102, TRIES, 1'b0);
        start_run();
        wait_done("R7", 1'b1, 1'b1);

        // R9: error on the port 3 read aborts the run
        for (int p = 0; p < 3; p++) begin
            push_rd(PB + 5'(p), 16'h0003, 1'b0, 0, "R3");
            push_wr(PB + 5'(p), 16'h0000, 1'b0, "R3");
        end
        push_rd(PB + 5'd3, 16'h0000, 1'b1, 0, "R9");
        start_run();
        wait_done("R9", 1'b1, 1'b0);

        // R9: error on a command write
        push_rd(PB + 5'd1, 16'h0100, 1'b0, 0, "R2");
        push_wr(PB + 5'd1, 16'h0103, 1'b1, "R9");
        port_cmd(1, 1'b1);
        wait_done("R9", 1'b1, 1'b0);

        // R9: next accepted command clears the flags
        push_rd(PB + 5'd0, 16'h2462, 1'b0, 0, "R2");
        push_wr(PB + 5'd0, 16'h2460, 1'b0, "R8");
        port_cmd(0, 1'b0);
        wait_done("R9", 1'b0, 1'b0);

        summary();
        $finish;
    end
endmodule